// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block gives two ports that share a memory a way to signal each other. Two addresses at the top of the address space serve as mailboxes. The address one below the top belongs to the left port and the topmost address belongs to the right port. When one port writes into the other port's mailbox, the block raises that other port's interrupt. The interrupted port acknowledges by reading its own mailbox, which releases the interrupt. The mailbox bytes stay in the shared memory outside this block and are never interpreted here.

Each port brings its active-low chip enable, write strobe and output enable, its address, and an active-low busy input from the arbiter. A busy port's mailbox accesses have no side effect on the flags. Each flag is a small registered state machine. Its states are `FLG_IDLE`, where the interrupt output is high, and `FLG_PENDING`, where the interrupt output is low. Its transitions are:
- RAISE: `FLG_IDLE` to `FLG_PENDING` on a qualifying write by the opposite port.
- ACK: `FLG_PENDING` to `FLG_IDLE` on a qualifying read by the owning port, provided no RAISE occurs in the same cycle.
- MUTE: any state to `FLG_IDLE` while the mailbox function is disabled.

A global enable turns the mailbox function off. While it is off, both interrupts stay high and the two addresses behave as plain memory.

Top module: `mbx_irq_top`

## Requirements
- R1: During and after reset, both `l_irq_n` and `r_irq_n` are high, and both flags are in `FLG_IDLE`.
- R2: The left mailbox address is 2^ADDR_W-2 (0x3FE by default). When the right port writes this address, `l_irq_n` is low after the next rising clock edge. A write requires `r_ce_n`=0, `r_we_n`=0 and `r_busy_n`=1.
- R3: When the left port accesses the left mailbox address with `l_ce_n`=0, `l_oe_n`=0 and `l_busy_n`=1, `l_irq_n` is high after the next edge. The value of `l_we_n` does not matter for this.
- R4: The right mailbox address is 2^ADDR_W-1 (0x3FF by default). When the left port writes this address with `l_ce_n`=0, `l_we_n`=0 and `l_busy_n`=1, `r_irq_n` is low after the next edge.
- R5: When the right port accesses the right mailbox address with `r_ce_n`=0, `r_oe_n`=0 and `r_busy_n`=1, `r_irq_n` is high after the next edge. The value of `r_we_n` does not matter for this.
- R6: A write to a mailbox by a port whose busy input is low does not change any flag.
- R7: A read of its own mailbox by a port whose busy input is low leaves a pending flag low.
- R8: The flags do not change in any of these cases:
  - an access to any address other than the two mailboxes;
  - a write by a port to its own mailbox;
  - a read by a port of the other port's mailbox;
  - an access with chip enable high.
- R9: When a RAISE and an ACK of the same flag occur in the same cycle, the flag is low after the edge.
- R10: While `mbx_en`=0, both interrupt outputs are high after the next edge and mailbox writes raise nothing. Once `mbx_en` returns to 1, the flags respond to accesses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mbx_en | input | 1 | Mailbox function enable, active high |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_busy_n | input | 1 | Left busy from arbiter, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_busy_n | input | 1 | Right busy from arbiter, active low |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with ADDR_W=4. This shrinks the space to 16 addresses while keeping both mailboxes at the top two locations, so the decode logic is the same as at full width. At that size the bench can sweep every address against all 16 control and busy combinations, from each port, with both flags starting idle and with both starting pending. That sweep reaches every RAISE, ACK and suppressed case. Directed sequences then cover the same-cycle race and the mute path through `mbx_en`.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [0:0] {
        FLG_IDLE    = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_e;

    // Side effects that one port's current access can cause.
    typedef struct packed {
        logic wr_lo;   // qualified write to the lower mailbox
        logic wr_hi;   // qualified write to the upper mailbox
        logic rd_lo;   // qualified read of the lower mailbox
        logic rd_hi;   // qualified read of the upper mailbox
    } port_hits_t;

    localparam int NUM_PORTS = 2;
    localparam int LEFT      = 0;
    localparam int RIGHT     = 1;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              busy_n,
    input  logic [ADDR_W-1:0] addr,
    output port_hits_t        hits
);
    localparam logic [ADDR_W-1:0] MB_HI = '1;
    localparam logic [ADDR_W-1:0] MB_LO = MB_HI - {{(ADDR_W-1){1'b0}}, 1'b1};

    logic wr_ok;
    logic rd_ok;
    logic at_lo;
    logic at_hi;

    always_comb begin
        // a busy port has no side effects
        wr_ok = !ce_n && !we_n && busy_n;
        rd_ok = !ce_n && !oe_n && busy_n;
        at_lo = (addr == MB_LO);
        at_hi = (addr == MB_HI);
        hits.wr_lo = wr_ok && at_lo;
        hits.wr_hi = wr_ok && at_hi;
        hits.rd_lo = rd_ok && at_lo;
        hits.rd_hi = rd_ok && at_hi;
    end

endmodule

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic raise,
    input  logic ack,
    output logic irq_n
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (enable && raise) state_d = FLG_PENDING;   // RAISE
            end
            FLG_PENDING: begin
                if (!enable)               state_d = FLG_IDLE; // MUTE
                else if (ack && !raise)    state_d = FLG_IDLE; // ACK, raise wins
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != FLG_PENDING);
    end

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbx_en,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_n,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_n,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    logic [NUM_PORTS-1:0] ce_v, we_v, oe_v, busy_v;
    logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
    port_hits_t           hits   [NUM_PORTS];
    logic [NUM_PORTS-1:0] raise_v, ack_v, irq_v;

    always_comb begin
        ce_v   = {r_ce_n,   l_ce_n};
        we_v   = {r_we_n,   l_we_n};
        oe_v   = {r_oe_n,   l_oe_n};
        busy_v = {r_busy_n, l_busy_n};
        addr_v[LEFT]  = l_addr;
        addr_v[RIGHT] = r_addr;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mbx_port_decode #(.ADDR_W(ADDR_W)) u_dec (
            .ce_n   (ce_v[p]),
            .we_n   (we_v[p]),
            .oe_n   (oe_v[p]),
            .busy_n (busy_v[p]),
            .addr   (addr_v[p]),
            .hits   (hits[p])
        );

        // left owns the lower mailbox, right owns the upper one
        if (p == LEFT) begin : g_lo
            assign raise_v[p] = hits[RIGHT].wr_lo;
            assign ack_v[p]   = hits[LEFT].rd_lo;
        end else begin : g_hi
            assign raise_v[p] = hits[LEFT].wr_hi;
            assign ack_v[p]   = hits[RIGHT].rd_hi;
        end

        mbx_flag_fsm u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (mbx_en),
            .raise  (raise_v[p]),
            .ack    (ack_v[p]),
            .irq_n  (irq_v[p])
        );
    end

    assign l_irq_n = irq_v[LEFT];
    assign r_irq_n = irq_v[RIGHT];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mbx_en,
    input logic              l_ce_n,
    input logic              l_we_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy_n,
    input logic              r_ce_n,
    input logic              r_we_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_n,
    input logic              l_irq_n,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] TOP = '1;
    localparam logic [ADDR_W-1:0] BOT = TOP - {{(ADDR_W-1){1'b0}}, 1'b1};

    logic l_set, l_clr, r_set, r_clr;
    always_comb begin
        l_set = !r_ce_n && !r_we_n && r_busy_n && (r_addr == BOT);
        l_clr = !l_ce_n && !l_oe_n && l_busy_n && (l_addr == BOT);
        r_set = !l_ce_n && !l_we_n && l_busy_n && (l_addr == TOP);
        r_clr = !r_ce_n && !r_oe_n && r_busy_n && (r_addr == TOP);
    end

    // R2 and R9: a qualifying write raises the flag even against an ack
    p_left_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mbx_en && l_set) |=> !l_irq_n);
    p_left_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mbx_en && l_clr && !l_set) |=> l_irq_n);
    p_right_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mbx_en && r_set) |=> !r_irq_n);
    p_right_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mbx_en && r_clr && !r_set) |=> r_irq_n);
    p_left_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_irq_n && !l_set) |=> l_irq_n);
    p_right_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_irq_n && !r_set) |=> r_irq_n);
    p_left_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_irq_n && mbx_en && !l_clr) |=> !l_irq_n);
    p_right_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_irq_n && mbx_en && !r_clr) |=> !r_irq_n);
    p_muted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mbx_en |=> (l_irq_n && r_irq_n));

endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en),
    .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
    .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/tb_mbx_irq_top.sv
`timescale 1ns/1ps
module tb_mbx_irq_top;
    localparam int W    = 4;
    localparam int MB_L = (1 << W) - 2;
    localparam int MB_R = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n, mbx_en;
    logic l_ce_n, l_we_n, l_oe_n, l_busy_n;
    logic r_ce_n, r_we_n, r_oe_n, r_busy_n;
    logic [W-1:0] l_addr, r_addr;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mbx_irq_top #(.ADDR_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en),
        .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
        .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        l_ce_n = 1; l_we_n = 1; l_oe_n = 1; l_busy_n = 1; l_addr = '0;
        r_ce_n = 1; r_we_n = 1; r_oe_n = 1; r_busy_n = 1; r_addr = '0;
    endtask

    task automatic check(string req, logic exp_l, logic exp_r);
        checks++;
        if (l_irq_n !== exp_l || r_irq_n !== exp_r) begin
            fails++;
            $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b", req, l_irq_n, r_irq_n, exp_l, exp_r);
        end
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        step();
        rst_n = 1;
        step();
    endtask

    // both ports post to each other in the same cycle
    task automatic raise_both();
        l_ce_n = 0; l_we_n = 0; l_addr = W'(MB_R);
        r_ce_n = 0; r_we_n = 0; r_addr = W'(MB_L);
        step();
        idle();
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        mbx_en = 1;
        idle();
        rst_n = 0;
        @(negedge clk);
        check("R1", 1'b1, 1'b1);
        rst_n = 1;
        step();
        check("R1", 1'b1, 1'b1);

        // sweep: port, starting state, address, {ce,we,oe,busy}
        for (int side = 0; side < 2; side++) begin
            for (int pre = 0; pre < 2; pre++) begin
                for (int a = 0; a < (1 << W); a++) begin
                    for (int c = 0; c < 16; c++) begin
                        bit ce, we, oe, bz, wr_ok, rd_ok, pl, pr;
                        string tag;
                        do_reset();
                        if (pre != 0) raise_both();
                        ce = c[3]; we = c[2]; oe = c[1]; bz = c[0];
                        if (side == 0) begin
                            l_ce_n = ce; l_we_n = we; l_oe_n = oe; l_busy_n = bz; l_addr = W'(a);
                        end else begin
                            r_ce_n = ce; r_we_n = we; r_oe_n = oe; r_busy_n = bz; r_addr = W'(a);
                        end
                        step();
                        idle();
                        pl = (pre != 0);
                        pr = (pre != 0);
                        wr_ok = !ce && !we && bz;
                        rd_ok = !ce && !oe && bz;
                        tag = "R8";
                        if (side == 0) begin
                            if (wr_ok && a == MB_R) begin pr = 1; tag = "R4"; end
                            if (rd_ok && a == MB_L) begin pl = 0; tag = "R3"; end
                            if (!bz && !ce && a == MB_R && !we) tag = "R6";
                            if (!bz && !ce && a == MB_L && !oe) tag = "R7";
                        end else begin
                            if (wr_ok && a == MB_L) begin pl = 1; tag = "R2"; end
                            if (rd_ok && a == MB_R) begin pr = 0; tag = "R5"; end
                            if (!bz && !ce && a == MB_L && !we) tag = "R6";
                            if (!bz && !ce && a == MB_R && !oe) tag = "R7";
                        end
                        check(tag, !pl, !pr);
                    end
                end
            end
        end

        // R9: raise and ack of the right flag in one cycle, flag pending
        do_reset();
        raise_both();
        l_ce_n = 0; l_we_n = 0; l_addr = W'(MB_R);
        r_ce_n = 0; r_oe_n = 0; r_addr = W'(MB_R);
        step();
        idle();
        check("R9", 1'b0, 1'b0);
        // R9: same race on the left flag starting idle
        do_reset();
        r_ce_n = 0; r_we_n = 0; r_addr = W'(MB_L);
        l_ce_n = 0; l_oe_n = 0; l_addr = W'(MB_L);
        step();
        idle();
        check("R9", 1'b0, 1'b1);

        // R10: mute pending flags, block raises, then resume
        do_reset();
        raise_both();
        check("R10", 1'b0, 1'b0);
        mbx_en = 0;
        step();
        check("R10", 1'b1, 1'b1);
        raise_both();
        check("R10", 1'b1, 1'b1);
        mbx_en = 1;
        step();
        check("R10", 1'b1, 1'b1);
        raise_both();
        check("R10", 1'b0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule